// File: doc/BRIEF.md
# Serial NAND Flash Command Phase Sequencer

This block is the host-side engine that carries out one serial NAND flash operation on a SPI bus with one, two or four data lanes. A single request gives the whole operation. The request sets the opcode byte, how many address bytes to send, how many dummy bytes to clock and the data length and direction. It also sets a separate lane width for the address, the dummy phase and the data phase. The engine then frames the operation with chip select, generates the serial clock and moves bytes through streaming ports. Outgoing payload bytes are pulled one at a time, and received bytes are pushed out as they complete.

The phases run in the fixed order opcode, address, dummy, data. Any of the last three may be absent. Short commands (reset, write enable) send only the opcode. Register and erase commands add one or three address bytes. The cache reads combine all four phases. Because the lane width is chosen per phase, the opcode can go out on one line while the later phases use two or four. The engine switches the IO output enables each phase: they are on while it transmits and off while the flash may drive the lines.

Top module: `spinand_seq`

## Requirements
- R1: Out of reset and between operations, cs_n is 1, sclk is 0, io_oe is 0, req_ready is 1, and done, rx_valid and tx_req are 0.
- R2: A request is taken in a cycle where req_valid and req_ready are both 1. req_ready is 0 from the next cycle until the cycle after done. While busy, req_valid and every request field are ignored and do not change the operation in progress.
- R3: cs_n goes low in the cycle after acceptance, with sclk low, so the first rising edge comes one clock later. After the last falling sclk edge cs_n stays low for one more cycle. It then goes high for a cycle with done=1 and req_ready=0, and req_ready returns the cycle after that.
- R4: Each bit slot is one cycle with sclk low, during which new output bits are driven, then one cycle with sclk high. io_out does not change while sclk is high. Input lines are sampled at the rising edge.
- R5: The opcode is always exactly one byte on the single-lane encoding, MSB first, with io_oe = 4'b0001.
- R6: The address phase sends req_addr_bytes bytes (0 to 3). The first byte sent is the most significant of the selected low-order bytes of req_addr, and each byte goes out MSB first.
- R7: Lane code 0 is one lane: out on IO0, in on IO1, output-enable mask 4'b0001. Code 1 is two lanes on IO[1:0] with the higher-order bit on IO1, mask 4'b0011. Codes 2 and 3 are four lanes on IO[3:0] with the highest bit on IO3, mask 4'b1111. A byte takes 8, 4 or 2 slots respectively.
- R8: The dummy phase clocks req_dummy_bytes bytes at the dummy lane width, with io_oe = 0 throughout.
- R9: For a write (req_data_out=1) tx_req pulses once per data byte, in the sclk-high cycle that ends the previous byte. tx_data is taken at the end of that cycle and driven from the next cycle.
- R10: For a read (req_data_out=0) io_oe stays 0. The received byte is output on rx_data with a one-cycle rx_valid pulse in the sclk-high cycle of the byte's last slot.
- R11: Phases with a zero count are skipped entirely, and the phases always run in the order opcode, address, dummy, data. An opcode-only operation gives exactly 8 sclk pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle and able to take a request |
| req_opcode | input | 8 | Command byte |
| req_addr | input | 24 | Address value, low-order bytes used |
| req_addr_bytes | input | 2 | Number of address bytes, 0 to 3 |
| req_addr_lanes | input | 2 | Lane code of the address phase |
| req_dummy_bytes | input | 3 | Number of dummy bytes |
| req_dummy_lanes | input | 2 | Lane code of the dummy phase |
| req_data_len | input | 12 | Number of data bytes |
| req_data_lanes | input | 2 | Lane code of the data phase |
| req_data_out | input | 1 | 1 = write data to the flash, 0 = read |
| tx_req | output | 1 | Pull strobe for the next outgoing byte |
| tx_data | input | 8 | Outgoing byte, taken when tx_req is high |
| rx_valid | output | 1 | Received byte strobe |
| rx_data | output | 8 | Received byte |
| done | output | 1 | One-cycle pulse at the end of an operation |
| sclk | output | 1 | Serial clock, idle low |
| cs_n | output | 1 | Active-low chip select |
| io_out | output | 4 | Values driven on IO[3:0] |
| io_oe | output | 4 | Per-line output enables |
| io_in | input | 4 | Values read from IO[3:0] |

## Verification
A wrong phase or lane state shows up on the IO lines within the same bit slot. The output-enable mask, the driven bit group and the number of slots per byte all change together, so an off-by-one in phase advance moves every later bit and is seen at the next sclk-low cycle. A counter that is wrong at a byte boundary either lengthens the frame or shortens it. Either way the chip-select release and done arrive in the wrong cycle. A bad capture path corrupts rx_data at the first rx_valid pulse. Requests poked while the engine is busy would change the bit stream at once if any field leaked into the running operation.

// File: rtl/spinand_seq_pkg.sv
`timescale 1ns/1ps
package spinand_seq_pkg;

  typedef enum logic [1:0] {
    PH_OPC   = 2'd0,
    PH_ADDR  = 2'd1,
    PH_DUMMY = 2'd2,
    PH_DATA  = 2'd3
  } phase_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_TAIL = 2'd2,
    ST_FIN  = 2'd3
  } state_e;

  typedef struct packed {
    logic   ok;
    phase_e ph;
  } nxt_t;

  // bit slots per byte minus one, per lane code
  function automatic logic [2:0] slots_m1(input logic [1:0] code);
    case (code)
      2'd0:    return 3'd7;
      2'd1:    return 3'd3;
      default: return 3'd1;
    endcase
  endfunction

  function automatic logic [3:0] lane_mask(input logic [1:0] code);
    case (code)
      2'd0:    return 4'b0001;
      2'd1:    return 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

  // first present phase after cur
  function automatic nxt_t next_phase(input phase_e cur, input logic has_a,
                                      input logic has_d, input logic has_x);
    nxt_t r;
    r.ok = 1'b0;
    r.ph = PH_DATA;
    case (cur)
      PH_OPC: begin
        if (has_a)      begin r.ok = 1'b1; r.ph = PH_ADDR;  end
        else if (has_d) begin r.ok = 1'b1; r.ph = PH_DUMMY; end
        else if (has_x) begin r.ok = 1'b1; r.ph = PH_DATA;  end
      end
      PH_ADDR: begin
        if (has_d)      begin r.ok = 1'b1; r.ph = PH_DUMMY; end
        else if (has_x) begin r.ok = 1'b1; r.ph = PH_DATA;  end
      end
      PH_DUMMY: begin
        if (has_x)      begin r.ok = 1'b1; r.ph = PH_DATA;  end
      end
      default: ;
    endcase
    return r;
  endfunction

  function automatic logic [3:0] out_bits(input logic [7:0] sh, input logic [1:0] code);
    case (code)
      2'd0:    return {3'b000, sh[7]};
      2'd1:    return {2'b00, sh[7:6]};
      default: return sh[7:4];
    endcase
  endfunction

  function automatic logic [7:0] shift_out(input logic [7:0] sh, input logic [1:0] code);
    case (code)
      2'd0:    return {sh[6:0], 1'b0};
      2'd1:    return {sh[5:0], 2'b00};
      default: return {sh[3:0], 4'b0000};
    endcase
  endfunction

  function automatic logic [7:0] shift_in(input logic [7:0] sh, input logic [1:0] code,
                                          input logic [3:0] io);
    case (code)
      2'd0:    return {sh[6:0], io[1]};
      2'd1:    return {sh[5:0], io[1:0]};
      default: return {sh[3:0], io[3:0]};
    endcase
  endfunction

endpackage

// File: rtl/spinand_phase_ctl.sv
`timescale 1ns/1ps
module spinand_phase_ctl
  import spinand_seq_pkg::*;
#(
  parameter int AB_W  = 2,
  parameter int DUM_W = 3,
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [AB_W-1:0]  req_addr_bytes,
  input  logic [1:0]       req_addr_lanes,
  input  logic [DUM_W-1:0] req_dummy_bytes,
  input  logic [1:0]       req_dummy_lanes,
  input  logic [LEN_W-1:0] req_data_len,
  input  logic [1:0]       req_data_lanes,
  input  logic             req_data_out,
  output logic             run,
  output phase_e           ph,
  output logic [1:0]       cur_code,
  output logic             data_out,
  output logic             ev_start,
  output logic             ev_rise,
  output logic             ev_fall,
  output logic             slot_last,
  output logic             ev_load,
  output phase_e           load_ph,
  output logic             sclk,
  output logic             cs_n,
  output logic             done,
  output logic             req_ready
);

  state_e           st;
  logic             half;
  logic [2:0]       slot;
  logic [LEN_W-1:0] bcnt;
  logic [AB_W-1:0]  abytes;
  logic [DUM_W-1:0] dbytes;
  logic [LEN_W-1:0] dlen;
  logic [1:0]       a_code, d_code, x_code;
  nxt_t             nxt;
  logic             more_same;

  function automatic logic [1:0] code_of(input phase_e p);
    case (p)
      PH_ADDR:  return a_code;
      PH_DUMMY: return d_code;
      PH_DATA:  return x_code;
      default:  return 2'd0;
    endcase
  endfunction

  function automatic logic [LEN_W-1:0] init_of(input phase_e p);
    case (p)
      PH_ADDR:  return LEN_W'(abytes) - LEN_W'(1);
      PH_DUMMY: return LEN_W'(dbytes) - LEN_W'(1);
      PH_DATA:  return dlen - LEN_W'(1);
      default:  return '0;
    endcase
  endfunction

  assign nxt       = next_phase(ph, abytes != '0, dbytes != '0, dlen != '0);
  assign run       = (st == ST_RUN);
  assign ev_start  = (st == ST_IDLE) && req_valid;
  assign ev_rise   = run && !half;
  assign ev_fall   = run && half;
  assign slot_last = (slot == 3'd0);
  assign more_same = (bcnt != '0);
  assign ev_load   = ev_fall && slot_last && (more_same || nxt.ok);
  assign load_ph   = more_same ? ph : nxt.ph;
  assign cur_code  = code_of(ph);

  assign sclk      = run && half;
  assign cs_n      = !(run || st == ST_TAIL);
  assign done      = (st == ST_FIN);
  assign req_ready = (st == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      ph       <= PH_OPC;
      half     <= 1'b0;
      slot     <= 3'd0;
      bcnt     <= '0;
      abytes   <= '0;
      dbytes   <= '0;
      dlen     <= '0;
      a_code   <= 2'd0;
      d_code   <= 2'd0;
      x_code   <= 2'd0;
      data_out <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (req_valid) begin
          abytes   <= req_addr_bytes;
          dbytes   <= req_dummy_bytes;
          dlen     <= req_data_len;
          a_code   <= req_addr_lanes;
          d_code   <= req_dummy_lanes;
          x_code   <= req_data_lanes;
          data_out <= req_data_out;
          ph       <= PH_OPC;
          half     <= 1'b0;
          slot     <= 3'd7;
          bcnt     <= '0;
          st       <= ST_RUN;
        end
        ST_RUN: begin
          half <= !half;
          if (half) begin
            if (!slot_last) begin
              slot <= slot - 3'd1;
            end else if (more_same) begin
              bcnt <= bcnt - LEN_W'(1);
              slot <= slots_m1(cur_code);
            end else if (nxt.ok) begin
              ph   <= nxt.ph;
              bcnt <= init_of(nxt.ph);
              slot <= slots_m1(code_of(nxt.ph));
            end else begin
              st <= ST_TAIL;
            end
          end
        end
        ST_TAIL: st <= ST_FIN;
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/spinand_lane_shift.sv
`timescale 1ns/1ps
module spinand_lane_shift
  import spinand_seq_pkg::*;
#(
  parameter int ADDR_MAX_BYTES = 3,
  parameter int AB_W           = 2,
  parameter int ADDR_W         = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_start,
  input  logic [7:0]        req_opcode,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [AB_W-1:0]   req_addr_bytes,
  input  logic              run,
  input  phase_e            ph,
  input  logic [1:0]        cur_code,
  input  logic              data_out,
  input  logic              ev_rise,
  input  logic              ev_fall,
  input  logic              slot_last,
  input  logic              ev_load,
  input  phase_e            load_ph,
  input  logic [7:0]        tx_data,
  input  logic [3:0]        io_in,
  output logic [3:0]        io_out,
  output logic [3:0]        io_oe,
  output logic              rx_valid,
  output logic [7:0]        rx_data
);

  logic [7:0]        sh;
  logic [ADDR_W-1:0] addr_sh;
  logic              drive;
  logic              capture;

  // left-align the selected low-order address bytes
  function automatic logic [ADDR_W-1:0] align_addr(input logic [ADDR_W-1:0] a,
                                                    input logic [AB_W-1:0] n);
    return a << (8 * (ADDR_MAX_BYTES - int'(n)));
  endfunction

  assign drive   = run && (ph == PH_OPC || ph == PH_ADDR || (ph == PH_DATA && data_out));
  assign capture = run && ph == PH_DATA && !data_out;
  assign io_out  = drive ? out_bits(sh, cur_code) : 4'b0000;
  assign io_oe   = drive ? lane_mask(cur_code) : 4'b0000;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh       <= '0;
      addr_sh  <= '0;
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else begin
      rx_valid <= 1'b0;
      if (ev_start) begin
        sh      <= req_opcode;
        addr_sh <= align_addr(req_addr, req_addr_bytes);
      end else if (ev_load) begin
        case (load_ph)
          PH_ADDR: begin
            sh      <= addr_sh[ADDR_W-1 -: 8];
            addr_sh <= addr_sh << 8;
          end
          PH_DATA: sh <= data_out ? tx_data : 8'h00;
          default: sh <= 8'h00;
        endcase
      end else if (ev_fall && !slot_last && drive) begin
        sh <= shift_out(sh, cur_code);
      end else if (ev_rise && capture) begin
        sh <= shift_in(sh, cur_code, io_in);
        if (slot_last) begin
          rx_valid <= 1'b1;
          rx_data  <= shift_in(sh, cur_code, io_in);
        end
      end
    end
  end

endmodule

// File: rtl/spinand_seq.sv
`timescale 1ns/1ps
module spinand_seq
  import spinand_seq_pkg::*;
#(
  parameter int ADDR_MAX_BYTES = 3,
  parameter int DUM_W          = 3,
  parameter int LEN_W          = 12,
  localparam int AB_W          = $clog2(ADDR_MAX_BYTES + 1),
  localparam int ADDR_W        = 8 * ADDR_MAX_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [7:0]        req_opcode,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [AB_W-1:0]   req_addr_bytes,
  input  logic [1:0]        req_addr_lanes,
  input  logic [DUM_W-1:0]  req_dummy_bytes,
  input  logic [1:0]        req_dummy_lanes,
  input  logic [LEN_W-1:0]  req_data_len,
  input  logic [1:0]        req_data_lanes,
  input  logic              req_data_out,
  output logic              tx_req,
  input  logic [7:0]        tx_data,
  output logic              rx_valid,
  output logic [7:0]        rx_data,
  output logic              done,
  output logic              sclk,
  output logic              cs_n,
  output logic [3:0]        io_out,
  output logic [3:0]        io_oe,
  input  logic [3:0]        io_in
);

  // named internal events, also used by the checker
  logic       run;
  phase_e     ph;
  logic [1:0] cur_code;
  logic       data_out;
  logic       ev_start, ev_rise, ev_fall, slot_last, ev_load;
  phase_e     load_ph;
  logic       in_dummy;

  assign tx_req   = ev_load && load_ph == PH_DATA && data_out;
  assign in_dummy = run && ph == PH_DUMMY;

  spinand_phase_ctl #(
    .AB_W (AB_W),
    .DUM_W(DUM_W),
    .LEN_W(LEN_W)
  ) u_ctl (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_addr_bytes (req_addr_bytes),
    .req_addr_lanes (req_addr_lanes),
    .req_dummy_bytes(req_dummy_bytes),
    .req_dummy_lanes(req_dummy_lanes),
    .req_data_len   (req_data_len),
    .req_data_lanes (req_data_lanes),
    .req_data_out   (req_data_out),
    .run            (run),
    .ph             (ph),
    .cur_code       (cur_code),
    .data_out       (data_out),
    .ev_start       (ev_start),
    .ev_rise        (ev_rise),
    .ev_fall        (ev_fall),
    .slot_last      (slot_last),
    .ev_load        (ev_load),
    .load_ph        (load_ph),
    .sclk           (sclk),
    .cs_n           (cs_n),
    .done           (done),
    .req_ready      (req_ready)
  );

  spinand_lane_shift #(
    .ADDR_MAX_BYTES(ADDR_MAX_BYTES),
    .AB_W          (AB_W),
    .ADDR_W        (ADDR_W)
  ) u_shift (
    .clk           (clk),
    .rst_n         (rst_n),
    .ev_start      (ev_start),
    .req_opcode    (req_opcode),
    .req_addr      (req_addr),
    .req_addr_bytes(req_addr_bytes),
    .run           (run),
    .ph            (ph),
    .cur_code      (cur_code),
    .data_out      (data_out),
    .ev_rise       (ev_rise),
    .ev_fall       (ev_fall),
    .slot_last     (slot_last),
    .ev_load       (ev_load),
    .load_ph       (load_ph),
    .tx_data       (tx_data),
    .io_in         (io_in),
    .io_out        (io_out),
    .io_oe         (io_oe),
    .rx_valid      (rx_valid),
    .rx_data       (rx_data)
  );

endmodule

// File: rtl/spinand_seq_chk.sv
`timescale 1ns/1ps
module spinand_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       done,
  input logic       sclk,
  input logic       cs_n,
  input logic [3:0] io_out,
  input logic [3:0] io_oe,
  input logic       rx_valid,
  input logic       tx_req,
  input logic       in_dummy
);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (io_oe == 4'b0000 && !sclk && !rx_valid && !tx_req));

  a_r2_accept_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!req_ready && !cs_n));

  a_r2_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !done) |=> !req_ready);

  a_r3_sclk_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> !cs_n);

  a_r3_done_frame: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cs_n && !req_ready));

  a_r3_ready_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (req_ready && !done));

  a_r4_one_cycle_high: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |=> !sclk);

  a_r4_hold_while_high: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> $stable(io_out));

  a_r7_mask_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (io_oe == 4'b0000 || io_oe == 4'b0001 || io_oe == 4'b0011 || io_oe == 4'b1111));

  a_r8_dummy_released: assert property (@(posedge clk) disable iff (!rst_n)
    in_dummy |-> io_oe == 4'b0000);

  a_r10_rx_on_high: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (sclk && io_oe == 4'b0000));

endmodule

bind spinand_seq spinand_seq_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .done     (done),
  .sclk     (sclk),
  .cs_n     (cs_n),
  .io_out   (io_out),
  .io_oe    (io_oe),
  .rx_valid (rx_valid),
  .tx_req   (tx_req),
  .in_dummy (in_dummy)
);

// File: tb/tb_spinand_seq.sv
`timescale 1ns/1ps
module tb_spinand_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [7:0]  req_opcode = '0;
  logic [23:0] req_addr = '0;
  logic [1:0]  req_addr_bytes = '0;
  logic [1:0]  req_addr_lanes = '0;
  logic [2:0]  req_dummy_bytes = '0;
  logic [1:0]  req_dummy_lanes = '0;
  logic [11:0] req_data_len = '0;
  logic [1:0]  req_data_lanes = '0;
  logic        req_data_out = 1'b0;
  logic        tx_req;
  logic [7:0]  tx_data;
  logic        rx_valid;
  logic [7:0]  rx_data;
  logic        done;
  logic        sclk;
  logic        cs_n;
  logic [3:0]  io_out;
  logic [3:0]  io_oe;
  logic [3:0]  io_in = '0;

  always #2.5 clk = ~clk;

  spinand_seq dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_opcode(req_opcode), .req_addr(req_addr), .req_addr_bytes(req_addr_bytes),
    .req_addr_lanes(req_addr_lanes), .req_dummy_bytes(req_dummy_bytes),
    .req_dummy_lanes(req_dummy_lanes), .req_data_len(req_data_len),
    .req_data_lanes(req_data_lanes), .req_data_out(req_data_out),
    .tx_req(tx_req), .tx_data(tx_data), .rx_valid(rx_valid), .rx_data(rx_data),
    .done(done), .sclk(sclk), .cs_n(cs_n), .io_out(io_out), .io_oe(io_oe),
    .io_in(io_in)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // expected bit-slot stream of one operation
  logic [3:0] e_io [512];
  logic [3:0] e_oe [512];
  logic [3:0] drv  [512];
  logic       e_rl [512];
  logic [7:0] e_rb [512];
  string      e_tag[512];
  int         nslots;

  logic [7:0] tx_mem [16];
  logic [7:0] rx_mem [16];
  int tx_cnt = 0;
  int tx_seen = 0;
  bit tx_pend = 0;

  assign tx_data = (tx_cnt < 16) ? tx_mem[tx_cnt] : 8'h00;

  always @(negedge clk) begin
    if (tx_pend) tx_cnt++;
    tx_pend = tx_req;
    if (tx_req) tx_seen++;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int lanes_of(input logic [1:0] code);
    return (code == 2'd0) ? 1 : (code == 2'd1) ? 2 : 4;
  endfunction

  // kind: 0 driven by host, 1 dummy, 2 read from flash
  task automatic push_byte(input logic [7:0] b, input logic [1:0] code,
                           input int kind, input string tag);
    int w = lanes_of(code);
    int n = 8 / w;
    for (int k = 0; k < n; k++) begin
      logic [3:0] bits, rnd;
      bits = 4'((int'(b) >> (8 - w * (k + 1))) & ((1 << w) - 1));
      rnd  = 4'($urandom);
      e_io[nslots] = 4'b0000;
      e_oe[nslots] = 4'b0000;
      e_rl[nslots] = 1'b0;
      e_rb[nslots] = b;
      e_tag[nslots] = tag;
      drv[nslots] = rnd;
      if (kind == 0) begin
        e_io[nslots] = bits;
        e_oe[nslots] = 4'((1 << w) - 1);
      end else if (kind == 2) begin
        if (w == 1)      drv[nslots] = {rnd[3:2], bits[0], rnd[0]};
        else if (w == 2) drv[nslots] = {rnd[3:2], bits[1:0]};
        else             drv[nslots] = bits;
        e_rl[nslots] = (k == n - 1);
      end
      nslots++;
    end
  endtask

  task automatic scramble();
    req_opcode      = 8'($urandom);
    req_addr        = 24'($urandom);
    req_addr_bytes  = 2'($urandom);
    req_addr_lanes  = 2'($urandom);
    req_dummy_bytes = 3'($urandom);
    req_dummy_lanes = 2'($urandom);
    req_data_len    = 12'($urandom);
    req_data_lanes  = 2'($urandom);
    req_data_out    = 1'($urandom);
  endtask

  task automatic run_op(input logic [7:0] op, input logic [23:0] addr,
                        input int ab, input logic [1:0] al,
                        input int db, input logic [1:0] dl,
                        input int xlen, input logic [1:0] xl, input bit xout,
                        input bit poke);
    logic [3:0] prev;
    nslots = 0;
    for (int i = 0; i < 16; i++) begin
      tx_mem[i] = 8'($urandom);
      rx_mem[i] = 8'($urandom);
    end
    push_byte(op, 2'd0, 0, "R5");
    for (int i = 0; i < ab; i++) push_byte(8'(addr >> (8 * (ab - 1 - i))), al, 0, "R6");
    for (int i = 0; i < db; i++) push_byte(8'h00, dl, 1, "R8");
    for (int i = 0; i < xlen; i++)
      if (xout) push_byte(tx_mem[i], xl, 0, "R9");
      else      push_byte(rx_mem[i], xl, 2, "R10");

    @(negedge clk);
    tx_cnt = 0; tx_seen = 0; tx_pend = 0;
    chk(req_ready == 1'b1, "R2 ready before request", int'(req_ready), 1);
    req_opcode = op; req_addr = addr; req_addr_bytes = 2'(ab); req_addr_lanes = al;
    req_dummy_bytes = 3'(db); req_dummy_lanes = dl; req_data_len = 12'(xlen);
    req_data_lanes = xl; req_data_out = xout; req_valid = 1'b1;
    @(negedge clk);
    req_valid = poke;
    if (poke) scramble();
    chk(!req_ready && !cs_n && !sclk, "R3 frame setup", {req_ready, cs_n, sclk}, 0);
    for (int s = 0; s < nslots; s++) begin
      io_in = drv[s];
      chk(!sclk && !cs_n, "R4 low half", {cs_n, sclk}, 0);
      chk(io_oe == e_oe[s], {"R7 oe ", e_tag[s]}, int'(io_oe), int'(e_oe[s]));
      chk((io_out & io_oe) == e_io[s], e_tag[s], int'(io_out & io_oe), int'(e_io[s]));
      prev = io_out;
      @(negedge clk);
      chk(sclk && !cs_n && io_out == prev, "R4 high half", {cs_n, sclk, io_out}, {2'b01, prev});
      chk(rx_valid == e_rl[s], "R10 rx strobe", int'(rx_valid), int'(e_rl[s]));
      if (e_rl[s]) chk(rx_data == e_rb[s], "R10 rx byte", int'(rx_data), int'(e_rb[s]));
      if (poke) scramble();
      @(negedge clk);
    end
    req_valid = 1'b0;
    chk(!cs_n && !sclk && !done, "R11 R3 tail cycle", {cs_n, sclk, done}, 0);
    @(negedge clk);
    chk(cs_n && done && !req_ready, "R3 done pulse", {cs_n, done, req_ready}, 3'b110);
    @(negedge clk);
    chk(cs_n && !done && req_ready && io_oe == 4'b0000, "R2 R1 back to idle",
        {cs_n, done, req_ready}, 3'b101);
    chk(tx_seen == (xout ? xlen : 0), "R9 tx pulls", tx_seen, xout ? xlen : 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk(cs_n && !sclk && io_oe == 0 && req_ready && !done && !rx_valid && !tx_req,
        "R1 in reset", {cs_n, sclk, req_ready, done}, 4'b1010);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(cs_n && !sclk && io_oe == 0 && req_ready && !done && !rx_valid && !tx_req,
        "R1 after reset", {cs_n, sclk, req_ready, done}, 4'b1010);

    // R11: opcode-only commands
    run_op(8'hFF, 24'h0, 0, 2'd0, 0, 2'd0, 0, 2'd0, 1'b0, 1'b0);
    run_op(8'h06, 24'h0, 0, 2'd0, 0, 2'd0, 0, 2'd0, 1'b0, 1'b1);
    // R6: three address bytes
    run_op(8'h13, 24'hA5C31E, 3, 2'd0, 0, 2'd0, 0, 2'd0, 1'b0, 1'b0);
    run_op(8'hD8, 24'h012345, 3, 2'd0, 0, 2'd0, 0, 2'd0, 1'b0, 1'b1);
    // register read and write
    run_op(8'h0F, 24'h0000C0, 1, 2'd0, 0, 2'd0, 1, 2'd0, 1'b0, 1'b0);
    run_op(8'h1F, 24'h0000A0, 1, 2'd0, 0, 2'd0, 1, 2'd0, 1'b1, 1'b0);
    // R8 R10: cache reads on various lanes
    run_op(8'h0B, 24'h000123, 2, 2'd0, 1, 2'd0, 4, 2'd0, 1'b0, 1'b0);
    run_op(8'h6B, 24'h000456, 2, 2'd0, 1, 2'd0, 5, 2'd2, 1'b0, 1'b0);
    run_op(8'hBB, 24'h000789, 2, 2'd1, 1, 2'd1, 3, 2'd1, 1'b0, 1'b1);
    run_op(8'hEB, 24'h000ABC, 2, 2'd2, 2, 2'd2, 6, 2'd2, 1'b0, 1'b0);
    // R9 R7: quad program load, lane code 3 behaving as four lanes
    run_op(8'h32, 24'h000010, 2, 2'd0, 0, 2'd0, 5, 2'd3, 1'b1, 1'b0);
    run_op(8'h34, 24'h000020, 2, 2'd3, 0, 2'd0, 8, 2'd1, 1'b1, 1'b1);
    // identification read: no address, dummy then data
    run_op(8'h9F, 24'h0, 0, 2'd0, 1, 2'd0, 4, 2'd0, 1'b0, 1'b0);

    for (int n = 0; n < 40; n++) begin
      run_op(8'($urandom), 24'($urandom), int'($urandom % 4), 2'($urandom),
             int'($urandom % 4), 2'($urandom), int'($urandom % 9), 2'($urandom),
             1'($urandom), 1'($urandom));
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule